// File: doc/BRIEF.md
# Sixteen-line GPIO controller with interrupt detection

This block controls sixteen general-purpose I/O lines through a small 32-bit register bus. The bus has a word address, a write strobe, write data and a combinational read-data return. Software sets an output value and a direction for each line. It reads the pin levels after they pass through a two-flop synchronizer.

Each line also has a programmable interrupt detector. The detector takes one of five styles: level high, level low, rising edge, falling edge, or any transition. A hit is latched in a status register. Software clears status bits by writing ones to them. Lines 0 to 12 each drive a dedicated active-high, level-sensitive interrupt output that follows the line's status bit. Lines 13 to 15 only set status.

Pads and tristate buffers sit outside the block, which exposes separate output, active-low output-enable and input vectors. The clock-output control word and the debounce-select word are held here for neighbouring logic, and they can be read back.

Top module: `gpio16_irq_ctrl`

## Requirements
- R1: After reset the registers hold these values: output data 0, direction 0xFFFF (all lines input), status 0, both style words 0, clock-control word 0, debounce word 0. Also after reset, `pin_out_o` is 0, `pin_oe_n_o` is 0xFFFF and `irq_o` is 0.
- R2: Word index 0 holds the output data and word index 1 holds the direction, each in bits 15:0. Bits 31:16 read as 0. `pin_out_o` follows the output data. `pin_oe_n_o` follows the direction, where 1 means input (driver off) and 0 means the output data is driven. Both outputs change one clock after the write.
- R3: Word index 2 returns the pin levels in bits 15:0, delayed by two clock edges. Writes to this index have no effect.
- R4: Word index 4 holds the styles of lines 0–7 and word index 5 holds the styles of lines 8–15. Line n occupies bits [3(n mod 8)+2 : 3(n mod 8)]. Bits 31:24 of both words read as 0.
- R5: Style 0 (level high) and style 1 (level low) set the line's status bit on every clock while the synchronized pin is at the active level. A clear written during that time does not take effect.
- R6: Style 2 (rising) and style 3 (falling) set the status bit on the selected edge of the synchronized pin, three clock edges after the pin changes. The bit then holds until software clears it.
- R7: Style 4 sets the status bit on either edge of the synchronized pin.
- R8: Style codes 5, 6 and 7 disable detection, so pin activity leaves the status bit at 0.
- R9: Word index 3 is the status, held in bits 15:0. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a detection and a clear fall on the same bit in the same cycle, the bit ends up set.
- R10: `irq_o[k]` equals status bit k for k = 0..12. Status bits 13–15 drive no interrupt output.
- R11: Word index 6 (clock control) and word index 7 (debounce select) store all 32 written bits and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word index (byte offset / 4) |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| pin_in_i | input | 16 | Pin levels from the pads, asynchronous |
| pin_out_o | output | 16 | Output data to the pads |
| pin_oe_n_o | output | 16 | Output enable, active low (1 = input) |
| irq_o | output | 13 | Interrupt outputs for lines 0–12, active high |

## Verification
Every status bit of lines 0–12 appears directly on `irq_o`, so a detector or status fault shows at the ports. A wrong set, a missed edge, or a clear that is lost or spurious appears there on the clock edge after it happens. On lines 13–15 the same fault can only be seen by reading word index 3.

The depth of the synchronizer and of the previous-value register is checked by reading status on the exact cycle before and after a detection must appear. A wrong delay therefore shifts a result by one read. Faults in the style field layout show up as a line reacting in the wrong way or as a neighbouring line firing. The tests program one line at a time while all the others are disabled.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam int unsigned STYLE_W      = 3;
  localparam int unsigned LINES_PER_SW = 8;

  typedef enum logic [2:0] {
    STY_LVL_HI = 3'd0,
    STY_LVL_LO = 3'd1,
    STY_RISE   = 3'd2,
    STY_FALL   = 3'd3,
    STY_ANY    = 3'd4
  } style_e;

  // word index = byte offset / 4
  typedef enum logic [2:0] {
    RI_OUT    = 3'd0,
    RI_DIR    = 3'd1,
    RI_IN     = 3'd2,
    RI_STAT   = 3'd3,
    RI_STY_LO = 3'd4,
    RI_STY_HI = 3'd5,
    RI_CLK    = 3'd6,
    RI_DBNC   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
  import gpio16_pkg::*;
(
  input  logic               cur_i,
  input  logic               prev_i,
  input  logic [STYLE_W-1:0] style_i,
  output logic               hit_o
);
  always_comb begin
    case (style_i)
      STY_LVL_HI: hit_o = cur_i;
      STY_LVL_LO: hit_o = ~cur_i;
      STY_RISE:   hit_o = cur_i & ~prev_i;
      STY_FALL:   hit_o = ~cur_i & prev_i;
      STY_ANY:    hit_o = cur_i ^ prev_i;
      default:    hit_o = 1'b0; // codes 5..7: detection off
    endcase
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio16_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 32,
  parameter int STY_W     = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           idx_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_LINES-1:0] line_in_i,
  input  logic [NUM_LINES-1:0] set_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_LINES-1:0] out_o,
  output logic [NUM_LINES-1:0] dir_o,
  output logic [NUM_LINES-1:0] status_o,
  output logic [STY_W-1:0]     sty_lo_o,
  output logic [STY_W-1:0]     sty_hi_o
);
  logic [NUM_LINES-1:0] out_q, dir_q, status_q, clr;
  logic [STY_W-1:0]     sty_lo_q, sty_hi_q;
  logic [DATA_W-1:0]    clk_q, dbnc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      dir_q    <= '1;
      sty_lo_q <= '0;
      sty_hi_q <= '0;
      clk_q    <= '0;
      dbnc_q   <= '0;
    end else if (we_i) begin
      case (idx_i)
        RI_OUT:    out_q    <= wdata_i[NUM_LINES-1:0];
        RI_DIR:    dir_q    <= wdata_i[NUM_LINES-1:0];
        RI_STY_LO: sty_lo_q <= wdata_i[STY_W-1:0];
        RI_STY_HI: sty_hi_q <= wdata_i[STY_W-1:0];
        RI_CLK:    clk_q    <= wdata_i;
        RI_DBNC:   dbnc_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr = (we_i && idx_i == RI_STAT) ? wdata_i[NUM_LINES-1:0] : '0;

  // set after clear: a same-cycle event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr) | set_i;
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      RI_OUT:    rdata_o[NUM_LINES-1:0] = out_q;
      RI_DIR:    rdata_o[NUM_LINES-1:0] = dir_q;
      RI_IN:     rdata_o[NUM_LINES-1:0] = line_in_i;
      RI_STAT:   rdata_o[NUM_LINES-1:0] = status_q;
      RI_STY_LO: rdata_o[STY_W-1:0]     = sty_lo_q;
      RI_STY_HI: rdata_o[STY_W-1:0]     = sty_hi_q;
      RI_CLK:    rdata_o                = clk_q;
      default:   rdata_o                = dbnc_q;
    endcase
  end

  assign out_o    = out_q;
  assign dir_o    = dir_q;
  assign status_o = status_q;
  assign sty_lo_o = sty_lo_q;
  assign sty_hi_o = sty_hi_q;
endmodule

// File: rtl/gpio16_irq_ctrl.sv
module gpio16_irq_ctrl
  import gpio16_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int IRQ_LINES   = 13,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [NUM_LINES-1:0] pin_in_i,
  output logic [NUM_LINES-1:0] pin_out_o,
  output logic [NUM_LINES-1:0] pin_oe_n_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  localparam int STY_W = STYLE_W * LINES_PER_SW;

  logic [NUM_LINES-1:0] line_in, prev_q, hit, status, dir;
  logic [STY_W-1:0]     sty_lo, sty_hi;
  logic [STYLE_W-1:0]   line_style [NUM_LINES];

  gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (line_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line_in;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i < LINES_PER_SW) begin : g_lo
      assign line_style[i] = sty_lo[STYLE_W*i +: STYLE_W];
    end else begin : g_hi
      assign line_style[i] = sty_hi[STYLE_W*(i-LINES_PER_SW) +: STYLE_W];
    end
    gpio_line_detect u_det (
      .cur_i  (line_in[i]),
      .prev_i (prev_q[i]),
      .style_i(line_style[i]),
      .hit_o  (hit[i])
    );
  end

  gpio_regfile #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .STY_W(STY_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .line_in_i(line_in),
    .set_i    (hit),
    .rdata_o  (reg_rdata_o),
    .out_o    (pin_out_o),
    .dir_o    (dir),
    .status_o (status),
    .sty_lo_o (sty_lo),
    .sty_hi_o (sty_hi)
  );

  assign pin_oe_n_o = dir;
  assign irq_o      = status[IRQ_LINES-1:0];
endmodule

// File: rtl/gpio16_irq_ctrl_chk.sv
module gpio16_irq_ctrl_chk
  import gpio16_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IRQ_LINES = 13,
  parameter int DATA_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           reg_addr_i,
  input logic                 reg_we_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [DATA_W-1:0]    reg_rdata_o,
  input logic [NUM_LINES-1:0] pin_out_o,
  input logic [NUM_LINES-1:0] pin_oe_n_o,
  input logic [IRQ_LINES-1:0] irq_o
);
  AST_OUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RI_OUT) |=> pin_out_o == $past(reg_wdata_i[NUM_LINES-1:0])); // R2

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RI_DIR) |=> pin_oe_n_o == $past(reg_wdata_i[NUM_LINES-1:0])); // R2

  AST_STY_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RI_STY_LO || reg_addr_i == RI_STY_HI) |-> reg_rdata_o[DATA_W-1:24] == '0); // R4

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == RI_STAT) |=> (($past(irq_o) & ~irq_o) == '0)); // R9

  AST_DBNC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(reg_we_i && reg_addr_i == RI_DBNC) && reg_addr_i == RI_DBNC)
      |-> reg_rdata_o == $past(reg_wdata_i)); // R11
endmodule

bind gpio16_irq_ctrl gpio16_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .IRQ_LINES(IRQ_LINES), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .pin_out_o  (pin_out_o),
  .pin_oe_n_o (pin_oe_n_o),
  .irq_o      (irq_o)
);

// File: tb/tb_gpio16_irq_ctrl.sv
module tb_gpio16_irq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pins = '0;
  logic [15:0] pout, poe_n;
  logic [12:0] irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  logic [23:0] sty_sh [2];

  always #(CLK_P/2) clk = ~clk;

  gpio16_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_in_i(pins),
    .pin_out_o(pout), .pin_oe_n_o(poe_n), .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk); addr = idx; we = 1; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(logic [2:0] idx, output logic [31:0] d);
    @(negedge clk); we = 0; addr = idx; #1 d = rdata;
  endtask

  task automatic set_pin(int line, logic v);
    @(negedge clk); pins[line] = v;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_style(int line, logic [2:0] code);
    int r = line / 8;
    int sh = 3 * (line % 8);
    sty_sh[r] = (sty_sh[r] & ~(24'h7 << sh)) | (24'(code) << sh);
    wr(3'(4 + r), {8'h0, sty_sh[r]});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1", "out reg", d, 0);
    rd(1, d); chk("R1", "dir reg", d, 32'hFFFF);
    rd(3, d); chk("R1", "status", d, 0);
    rd(4, d); chk("R1", "style lo", d, 0);
    rd(5, d); chk("R1", "style hi", d, 0);
    rd(6, d); chk("R1", "clock ctl", d, 0);
    rd(7, d); chk("R1", "debounce", d, 0);
    chk("R1", "pin_out", pout, 0);
    chk("R1", "pin_oe_n", poe_n, 32'hFFFF);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_style_layout();
    logic [31:0] d;
    wr(4, 32'hFFFF_FFFF); rd(4, d); chk("R4", "style lo upper zero", d, 32'h00FF_FFFF);
    wr(5, 32'hFFFF_FFFF); rd(5, d); chk("R4", "style hi upper zero", d, 32'h00FF_FFFF);
    sty_sh[0] = 24'hFFFFFF; sty_sh[1] = 24'hFFFFFF;
  endtask

  task automatic t_out_dir();
    logic [31:0] d;
    wr(0, 32'hFFFF_A5C3); rd(0, d); chk("R2", "out readback", d, 32'hA5C3);
    chk("R2", "pin_out", pout, 32'hA5C3);
    wr(1, 32'h1234_00FF); rd(1, d); chk("R2", "dir readback", d, 32'h00FF);
    chk("R2", "pin_oe_n", poe_n, 32'h00FF);
    wr(0, 0); chk("R2", "pin_out cleared", pout, 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk); pins = 16'h9A31;
    tick(1); rd(2, d); chk("R3", "input after 1 edge", d, 0);
    tick(1); rd(2, d); chk("R3", "input after 2 edges", d, 32'h9A31);
    wr(2, 32'h0000_FFFF); rd(2, d); chk("R3", "input write ignored", d, 32'h9A31);
    @(negedge clk); pins = '0; tick(3);
    rd(3, d); chk("R8", "status with all disabled", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_style(2, 3'd0);
    set_pin(2, 1); tick(3);
    rd(3, d); chk("R5", "level high sets", d, 32'h0004);
    chk("R10", "irq line 2", irq, 13'h0004);
    wr(3, 32'h0004); rd(3, d); chk("R5", "clear ignored while high", d, 32'h0004);
    set_pin(2, 0); tick(3);
    wr(3, 32'h0004); rd(3, d); chk("R5", "clear after release", d, 0);
    set_style(2, 3'd7);
    set_style(5, 3'd1); tick(1);
    rd(3, d); chk("R5", "level low sets", d, 32'h0020);
    set_style(5, 3'd7);
    wr(3, 32'h0020); rd(3, d); chk("R5", "level low cleared", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    set_style(10, 3'd2);
    set_pin(10, 1); tick(2);
    rd(3, d); chk("R6", "rising not yet at 2 edges", d, 0);
    tick(1); rd(3, d); chk("R6", "rising at 3 edges", d, 32'h0400);
    chk("R10", "irq line 10", irq, 13'h0400);
    set_pin(10, 0); tick(3);
    rd(3, d); chk("R6", "rising held after fall", d, 32'h0400);
    wr(3, 32'h0000_0000); rd(3, d); chk("R9", "write zero keeps", d, 32'h0400);
    wr(3, 32'h0000_0400); rd(3, d); chk("R9", "write one clears", d, 0);
    set_style(10, 3'd7);
    set_style(0, 3'd3);
    set_pin(0, 1); tick(3);
    rd(3, d); chk("R6", "falling ignores rise", d, 0);
    set_pin(0, 0); tick(3);
    rd(3, d); chk("R6", "falling sets", d, 32'h0001);
    chk("R10", "irq line 0", irq, 13'h0001);
    wr(3, 32'h0001); set_style(0, 3'd7);
    rd(3, d); chk("R9", "falling cleared", d, 0);
  endtask

  task automatic t_any();
    logic [31:0] d;
    set_style(7, 3'd4);
    set_pin(7, 1); tick(3);
    rd(3, d); chk("R7", "any edge on rise", d, 32'h0080);
    wr(3, 32'h0080); rd(3, d); chk("R7", "cleared", d, 0);
    set_pin(7, 0); tick(3);
    rd(3, d); chk("R7", "any edge on fall", d, 32'h0080);
    wr(3, 32'h0080); set_style(7, 3'd7);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    set_style(11, 3'd4);
    set_pin(11, 1); tick(3);
    rd(3, d); chk("R9", "line 11 set", d, 32'h0800);
    set_pin(11, 0); tick(2);
    wr(3, 32'h0800); // lands on the detection edge
    rd(3, d); chk("R9", "set wins over clear", d, 32'h0800);
    wr(3, 32'h0800); rd(3, d); chk("R9", "later clear", d, 0);
    set_style(11, 3'd7);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    set_style(4, 3'd5); set_style(9, 3'd6); set_style(13, 3'd7);
    @(negedge clk); pins = 16'h2210; tick(3);
    @(negedge clk); pins = 16'h0000; tick(3);
    rd(3, d); chk("R8", "codes 5-7 never set", d, 0);
    chk("R8", "irq idle", irq, 0);
  endtask

  task automatic t_high_lines();
    logic [31:0] d;
    set_style(12, 3'd2); set_style(14, 3'd2);
    @(negedge clk); pins = 16'h5000; tick(3);
    rd(3, d); chk("R10", "status 12 and 14", d, 32'h5000);
    chk("R10", "irq only line 12", irq, 13'h1000);
    wr(3, 32'h5000); rd(3, d); chk("R10", "cleared", d, 0);
    chk("R10", "irq low", irq, 0);
    @(negedge clk); pins = '0;
  endtask

  task automatic t_aux_regs();
    logic [31:0] d;
    wr(6, 32'hDEAD_BEEF); rd(6, d); chk("R11", "clock ctl", d, 32'hDEAD_BEEF);
    wr(6, 32'h0);         rd(6, d); chk("R11", "clock ctl zero", d, 0);
    wr(7, 32'h1234_5678); rd(7, d); chk("R11", "debounce", d, 32'h1234_5678);
  endtask

  initial begin
    tick(3);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_style_layout();
    t_out_dir();
    t_input();
    t_level();
    t_edge();
    t_any();
    t_set_wins();
    t_disabled();
    t_high_lines();
    t_aux_regs();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule